// File: doc/BRIEF.md
# PHY Status Stream Receiver

This block sits on the link side of a serial-bus link/PHY interface. It captures the status transfers that the PHY drives toward the link. While the two-bit control lines carry the status code, the block gathers status bits from the data lines at two bits per clock. When the control lines leave that code, the block judges the transfer by the number of bits it collected.

A four-bit transfer carries only the condition flags: arbitration-reset gap, fair gap, bus reset and PHY interrupt. A sixteen-bit transfer also carries a PHY register address and the data of that register. Any other length is discarded and reported as an error. The fair-gap and bus-reset flags also raise one-cycle event pulses, which the link's scheduling logic uses.

The link's control logic can register a pending PHY register read with a one-cycle request strobe. A later full transfer whose address matches that read completes it. A full transfer that matches no pending read is reported as unsolicited, for example the new node-ID report the PHY sends after self-identification.

Top module: `phyStatRx`

## Requirements
- R1: During and right after reset, every output is 0.
- R2: A status transfer is the run of clocks with ctl = 2'b01. Each such clock delivers two bits: d[0] is the lower-numbered bit and d[1] the next one, starting at bit 0.
- R3: The transfer ends on the first clock with ctl ≠ 2'b01. A transfer of exactly 4 bits updates the flag outputs from bits 0..3 and pulses flagValid for one cycle. The flag outputs are arbGap = bit 0, fairGap = bit 1, busRst = bit 2 and phyInt = bit 3. All of this appears in the cycle after the clock edge that samples the end.
- R4: A transfer of exactly 16 bits does everything R3 does. It also sets regAddr to bits 7..4 (bit 4 is the LSB) and regData to bits 15..8 (bit 8 is the LSB), and pulses regValid in the same cycle as flagValid.
- R5: A transfer of any other length gives a one-cycle xferErr pulse. It leaves the flags, regAddr and regData unchanged and raises no flagValid or regValid.
- R6: An accepted transfer with bit 1 set pulses cycleDone for one cycle. An accepted transfer with bit 2 set pulses busResetEvt for one cycle. Both pulses come in the same cycle as flagValid.
- R7: A one-cycle rdReq with rdAddr records a pending read. A later 16-bit transfer whose address equals rdAddr pulses readDone with regValid and clears the pending read.
- R8: A 16-bit transfer that matches no pending read pulses unsolicited with regValid. A pending read for a different address stays pending.
- R9: A 4-bit transfer or a rejected transfer neither completes nor clears a pending read.
- R10: Two transfers separated by a single non-status clock are both captured and reported separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctl | input | 2 | Control lines from the PHY; 2'b01 marks status |
| d | input | 2 | Data lines carrying status bits |
| rdReq | input | 1 | One-cycle strobe: a register read was issued |
| rdAddr | input | 4 | Register address of the issued read |
| arbGap | output | 1 | Arbitration-reset gap flag (bit 0) |
| fairGap | output | 1 | Fair gap flag (bit 1) |
| busRst | output | 1 | Bus reset flag (bit 2) |
| phyInt | output | 1 | PHY interrupt flag (bit 3) |
| flagValid | output | 1 | One-cycle pulse: flags updated |
| regValid | output | 1 | One-cycle pulse: register address/data updated |
| regAddr | output | 4 | Register address from the last full transfer |
| regData | output | 8 | Register data from the last full transfer |
| cycleDone | output | 1 | One-cycle pulse: fair gap reported |
| busResetEvt | output | 1 | One-cycle pulse: bus reset reported |
| readDone | output | 1 | One-cycle pulse: pending read completed |
| unsolicited | output | 1 | One-cycle pulse: full transfer without matching read |
| xferErr | output | 1 | One-cycle pulse: transfer of illegal length dropped |

## Verification
Every result of a transfer appears exactly one cycle after the edge that samples the first non-status control code. There is one register stage from that edge, and none from the status clocks before it. The reference model in the bench sees the same edges. It gathers bits in a queue while the status code is present. At the ending edge it judges the queue length, so its expected outputs change at the same edge as the design's. The outputs are compared at every falling edge, half a cycle after each change. Directed checks taken one falling edge after the ending idle clock confirm the literal flag, address and data values.

// File: rtl/phyStatPkg.sv
package phyStatPkg;

  typedef enum logic [1:0] {
    CTL_IDLE   = 2'b00,
    CTL_STATUS = 2'b01,
    CTL_RECV   = 2'b10,
    CTL_HOLD   = 2'b11
  } ctlCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // capture one lane group this cycle
    logic endShort;  // transfer closed with flag-only length
    logic endFull;   // transfer closed with full length
    logic endBad;    // transfer closed with illegal length
  } rxStrobe_t;

endpackage

// File: rtl/phyStatCtrl.sv
module phyStatCtrl
  import phyStatPkg::*;
#(
  parameter int FLAG_BITS = 4,
  parameter int FULL_BITS = 16,
  parameter int LANES     = 2,
  localparam int FLAG_CYC = FLAG_BITS / LANES,
  localparam int FULL_CYC = FULL_BITS / LANES,
  localparam int CNT_W    = $clog2(FULL_CYC + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       ctl,
  output rxStrobe_t        strb,
  output logic [CNT_W-1:0] slot
);

  logic [CNT_W-1:0] cycCnt;
  logic             inStatus;
  logic             ending;

  assign inStatus = (ctl == CTL_STATUS);
  assign ending   = !inStatus && (cycCnt != '0);
  assign slot     = cycCnt;

  always_comb begin
    strb          = '0;
    strb.shiftEn  = inStatus && (cycCnt < CNT_W'(FULL_CYC));
    strb.endShort = ending && (cycCnt == CNT_W'(FLAG_CYC));
    strb.endFull  = ending && (cycCnt == CNT_W'(FULL_CYC));
    strb.endBad   = ending && (cycCnt != CNT_W'(FLAG_CYC))
                           && (cycCnt != CNT_W'(FULL_CYC));
  end

  // counts status clocks; saturates one past the full length so that
  // an over-long transfer is still seen as illegal
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (inStatus) begin
      if (cycCnt != CNT_W'(FULL_CYC + 1)) cycCnt <= cycCnt + 1'b1;
    end else begin
      cycCnt <= '0;
    end
  end

endmodule

// File: rtl/phyStatData.sv
module phyStatData
  import phyStatPkg::*;
#(
  parameter int FULL_BITS = 16,
  parameter int LANES     = 2,
  parameter int FLAG_BITS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  localparam int FULL_CYC = FULL_BITS / LANES,
  localparam int CNT_W    = $clog2(FULL_CYC + 2),
  localparam int ADDR_LO  = FLAG_BITS,
  localparam int DATA_LO  = FLAG_BITS + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  d,
  input  rxStrobe_t         strb,
  input  logic [CNT_W-1:0]  slot,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [3:0]        flags,
  output logic              flagValid,
  output logic              regValid,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              cycleDone,
  output logic              busResetEvt,
  output logic              readDone,
  output logic              unsolicited,
  output logic              xferErr
);

  logic [FULL_BITS-1:0] shReg;
  logic                 pendValid;
  logic [ADDR_W-1:0]    pendAddr;
  logic                 accept;
  logic                 addrHit;

  // one capture register group per status clock slot
  for (genvar g = 0; g < FULL_CYC; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg[g*LANES +: LANES] <= '0;
      end else if (strb.shiftEn && (slot == CNT_W'(g))) begin
        shReg[g*LANES +: LANES] <= d;
      end
    end
  end

  assign accept  = strb.endShort || strb.endFull;
  assign addrHit = pendValid && (shReg[ADDR_LO +: ADDR_W] == pendAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags       <= '0;
      flagValid   <= 1'b0;
      regValid    <= 1'b0;
      regAddr     <= '0;
      regData     <= '0;
      cycleDone   <= 1'b0;
      busResetEvt <= 1'b0;
      readDone    <= 1'b0;
      unsolicited <= 1'b0;
      xferErr     <= 1'b0;
    end else begin
      flagValid   <= accept;
      regValid    <= strb.endFull;
      cycleDone   <= accept && shReg[1];
      busResetEvt <= accept && shReg[2];
      readDone    <= strb.endFull && addrHit;
      unsolicited <= strb.endFull && !addrHit;
      xferErr     <= strb.endBad;
      if (accept) flags <= shReg[3:0];
      if (strb.endFull) begin
        regAddr <= shReg[ADDR_LO +: ADDR_W];
        regData <= shReg[DATA_LO +: DATA_W];
      end
    end
  end

  // pending read: completion uses the old entry, a new request wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
    end else begin
      if (strb.endFull && addrHit) pendValid <= 1'b0;
      if (rdReq) begin
        pendValid <= 1'b1;
        pendAddr  <= rdAddr;
      end
    end
  end

endmodule

// File: rtl/phyStatRx.sv
module phyStatRx
  import phyStatPkg::*;
#(
  parameter int FLAG_BITS = 4,
  parameter int FULL_BITS = 16,
  parameter int LANES     = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  localparam int FULL_CYC = FULL_BITS / LANES,
  localparam int CNT_W    = $clog2(FULL_CYC + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        ctl,
  input  logic [LANES-1:0]  d,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              arbGap,
  output logic              fairGap,
  output logic              busRst,
  output logic              phyInt,
  output logic              flagValid,
  output logic              regValid,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regData,
  output logic              cycleDone,
  output logic              busResetEvt,
  output logic              readDone,
  output logic              unsolicited,
  output logic              xferErr
);

  rxStrobe_t        strb;
  logic [CNT_W-1:0] slot;
  logic [3:0]       flags;

  phyStatCtrl #(
    .FLAG_BITS(FLAG_BITS), .FULL_BITS(FULL_BITS), .LANES(LANES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctl(ctl), .strb(strb), .slot(slot)
  );

  phyStatData #(
    .FULL_BITS(FULL_BITS), .LANES(LANES), .FLAG_BITS(FLAG_BITS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .d(d), .strb(strb), .slot(slot),
    .rdReq(rdReq), .rdAddr(rdAddr), .flags(flags),
    .flagValid(flagValid), .regValid(regValid), .regAddr(regAddr),
    .regData(regData), .cycleDone(cycleDone), .busResetEvt(busResetEvt),
    .readDone(readDone), .unsolicited(unsolicited), .xferErr(xferErr)
  );

  assign arbGap  = flags[0];
  assign fairGap = flags[1];
  assign busRst  = flags[2];
  assign phyInt  = flags[3];

endmodule

// File: rtl/phyStatRx_chk.sv
module phyStatRx_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] ctl,
  input logic       fairGap,
  input logic       busRst,
  input logic       flagValid,
  input logic       regValid,
  input logic       cycleDone,
  input logic       busResetEvt,
  input logic       readDone,
  input logic       unsolicited,
  input logic       xferErr
);

  // R3
  flag_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> ($past(ctl) != 2'b01) && ($past(ctl, 2) == 2'b01));

  // R3
  flag_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |=> !flagValid);

  // R4
  reg_with_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    regValid |-> flagValid);

  // R5
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xferErr, flagValid}));

  // R6
  cycle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> flagValid && fairGap);

  // R6
  bus_reset_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    busResetEvt |-> flagValid && busRst);

  // R7
  read_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    readDone |-> regValid && !unsolicited);

  // R8
  unsolicited_chk: assert property (@(posedge clk) disable iff (!rstN)
    regValid |-> $countones({readDone, unsolicited}) == 1);

endmodule

bind phyStatRx phyStatRx_chk u_chk (.*);

// File: tb/phyStatRx_bench.sv
module phyStatRx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic [1:0] d = 2'b00;
  logic       rdReq = 1'b0;
  logic [3:0] rdAddr = 4'h0;
  logic       arbGap, fairGap, busRst, phyInt, flagValid, regValid;
  logic [3:0] regAddr;
  logic [7:0] regData;
  logic       cycleDone, busResetEvt, readDone, unsolicited, xferErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phyStatRx u_phyStatRx (
    .clk(clk), .rstN(rstN), .ctl(ctl), .d(d), .rdReq(rdReq), .rdAddr(rdAddr),
    .arbGap(arbGap), .fairGap(fairGap), .busRst(busRst), .phyInt(phyInt),
    .flagValid(flagValid), .regValid(regValid), .regAddr(regAddr),
    .regData(regData), .cycleDone(cycleDone), .busResetEvt(busResetEvt),
    .readDone(readDone), .unsolicited(unsolicited), .xferErr(xferErr)
  );

  // ---------------- reference model ----------------
  logic       q[$];
  logic [3:0] eFlags;
  logic [3:0] eAddr;
  logic [7:0] eData;
  logic eFv, eRv, eCyc, eBr, eRd, eUns, eErr;
  logic pend;
  logic [3:0] pendA;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      eFlags = 0; eAddr = 0; eData = 0;
      {eFv, eRv, eCyc, eBr, eRd, eUns, eErr} = '0;
      pend = 0; pendA = 0;
    end else begin
      {eFv, eRv, eCyc, eBr, eRd, eUns, eErr} = '0;
      if (ctl == 2'b01) begin
        q.push_back(d[0]);
        q.push_back(d[1]);
      end else if (q.size() > 0) begin
        if (q.size() == 4 || q.size() == 16) begin
          eFlags = {q[3], q[2], q[1], q[0]};
          eFv = 1; eCyc = q[1]; eBr = q[2];
          if (q.size() == 16) begin
            eRv = 1;
            eAddr = {q[7], q[6], q[5], q[4]};
            for (int i = 0; i < 8; i++) eData[i] = q[8 + i];
            if (pend && pendA == eAddr) begin eRd = 1; pend = 0; end
            else eUns = 1;
          end
        end else begin
          eErr = 1;
        end
        q.delete();
      end
      if (rdReq) begin pend = 1; pendA = rdAddr; end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        chk("R1 reset outputs", {arbGap, fairGap, busRst, phyInt, flagValid, regValid,
            cycleDone, busResetEvt, readDone, unsolicited, xferErr}, 16'h0);
      end else begin
        chk("R3 flags", {busRst, fairGap, arbGap, phyInt}, {eFlags[2], eFlags[1], eFlags[0], eFlags[3]});
        chk("R3 flagValid", flagValid, eFv);
        chk("R4 regValid", regValid, eRv);
        chk("R4 regAddr", regAddr, eAddr);
        chk("R2 R4 regData", regData, eData);
        chk("R6 cycleDone", cycleDone, eCyc);
        chk("R6 busResetEvt", busResetEvt, eBr);
        chk("R7 readDone", readDone, eRd);
        chk("R8 unsolicited", unsolicited, eUns);
        chk("R5 xferErr", xferErr, eErr);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input int nbits, input logic [31:0] v);
    for (int c = 0; c < nbits / 2; c++) begin
      @(negedge clk);
      ctl = 2'b01;
      d = v[2*c +: 2];
    end
  endtask

  task automatic send(input int nbits, input logic [31:0] v, input logic [1:0] endCode);
    drive(nbits, v);
    @(negedge clk);
    ctl = endCode;
    d = 2'b00;
    @(negedge clk);
    ctl = 2'b00;
  endtask

  task automatic readReq(input logic [3:0] a);
    @(negedge clk);
    rdReq = 1'b1; rdAddr = a;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {flagValid, regAddr, regData}, 16'h0);

    // R3 short transfers, one flag at a time and all together
    send(4, 32'h1, 2'b00);
    chk("R3 arbGap only", {phyInt, busRst, fairGap, arbGap, flagValid}, 5'b00011);
    send(4, 32'h2, 2'b00);
    chk("R6 cycleDone with fairGap", {fairGap, cycleDone}, 2'b11);
    send(4, 32'h4, 2'b00);
    chk("R6 busResetEvt with busRst", {busRst, busResetEvt}, 2'b11);
    send(4, 32'h8, 2'b10);
    chk("R3 phyInt, end by other code", {phyInt, arbGap}, 2'b10);
    send(4, 32'hF, 2'b00);

    // R4 unsolicited full transfer, R2 lane order
    send(16, 32'hA735, 2'b00);
    chk("R4 regAddr", regAddr, 4'h3);
    chk("R4 regData", regData, 8'hA7);
    chk("R8 unsolicited full", {regValid, unsolicited, readDone}, 3'b110);
    chk("R2 flags from low bits", {phyInt, busRst, fairGap, arbGap}, 4'h5);

    // R7 matched read
    readReq(4'h6);
    send(16, 32'h5C62, 2'b00);
    chk("R7 readDone", {readDone, unsolicited}, 2'b10);

    // R8 mismatched read stays pending, R9 short and bad keep it
    readReq(4'h9);
    send(16, 32'h11A0, 2'b00);
    chk("R8 mismatch unsolicited", {readDone, unsolicited}, 2'b01);
    send(4, 32'h3, 2'b00);
    send(8, 32'hFF, 2'b00);
    chk("R5 bad length err", {xferErr, flagValid}, 2'b10);
    send(16, 32'hE790, 2'b00);
    chk("R9 pending survives", {readDone, regData}, 9'h1E7);

    // R5 illegal lengths
    send(2, 32'h3, 2'b00);
    send(12, 32'hFFF, 2'b00);
    send(18, 32'h3FFFF, 2'b00);
    send(20, 32'hFFFFF, 2'b00);
    chk("R5 flags unchanged", {phyInt, busRst, fairGap, arbGap, regData}, {4'h0, 8'hE7});

    // R10 back-to-back with a single idle clock
    drive(4, 32'h6);
    @(negedge clk); ctl = 2'b00;
    drive(16, 32'h42B9);
    @(negedge clk); ctl = 2'b00;
    @(negedge clk);
    chk("R10 second transfer", {regAddr, regData}, 12'hB42);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule